// File: doc/BRIEF.md
# Raster LCD Panel Timing Generator

This block produces the horizontal and vertical timing that drives a raster LCD panel. The horizontal and vertical porch and sync widths are set by input registers, together with the visible width and height, a pixel clock divisor, the toggle period of the passive-panel bias signal, a per-signal polarity mask and the panel type. A divider cuts the core clock down to a pixel-rate enable. A horizontal counter walks each line through sync, back porch, visible pixels and front porch. A vertical counter moves forward once per line.

The outputs are a pixel clock enable, a pixel-request strobe for the upstream pixel fetch, line and frame sync, a data-enable for active-matrix (TFT) panels and a slow bias toggle for passive (STN) panels. Each of these comes from a register, and each sync/enable/bias signal can be inverted on its own. The current x/y position is also brought out. A vertical-compare event, placed at the start of one of the four vertical regions, sets a sticky status bit. That bit is cleared by a write-one strobe and reaches the interrupt pin only through a mask.

Top module: `lcd_tgen`

## Requirements
- R1: `pclk_en` pulses for one clock once every `cfg_div`+1 core clocks while `en` is high, which gives (line total × frame total) pulses per frame.
- R2: A line is `cfg_hsw`+`cfg_hbp`+`cfg_hact`+`cfg_hfp` pixels long, in the order sync, back porch, visible, front porch. `x_pos` runs from 0 to line total − 1. `hsync` is active for the first `cfg_hsw` pixels of each line.
- R3: `y_pos` advances once per line wrap and runs from 0 to frame total − 1, with the vertical regions in the same order. `vsync` is active for the first `cfg_vsw` lines.
- R4: With `cfg_tft`=1, `de` is active only on pixels that are visible both horizontally and vertically. With `cfg_tft`=0, `de` stays inactive.
- R5: `pix_req` is a one-clock strobe that coincides with `pclk_en` on every visible pixel, in both panel modes. That is `cfg_hact`×`cfg_vact` strobes per frame.
- R6: With `cfg_tft`=0, `acb` toggles after every `cfg_acb` line wraps, and a value of 0 acts as 1. With `cfg_tft`=1, `acb` stays inactive.
- R7: Polarity mask `cfg_pol`: bit 0 is hsync, bit 1 vsync, bit 2 de, bit 3 acb. A bit value of 1 makes that output active-low (inactive level 1).
- R8: `cfg_vcmp_sel` picks the compare line: 0 is line 0 (sync start), 1 is line `cfg_vsw`, 2 is line `cfg_vsw`+`cfg_vbp`, 3 is line `cfg_vsw`+`cfg_vbp`+`cfg_vact`. The event fires once per frame, on the first pixel of that line, so the cycle in which `irq_stat` becomes 1 shows `x_pos`=0 and `y_pos` equal to the compare line.
- R9: `irq_stat` is sticky. `irq_clr`=1 clears it on the next clock, and a coincident event wins over the clear. `irq` equals the next `irq_stat` AND `irq_mask`, registered, so `irq` is low one clock after `irq_mask` is low.
- R10: While `en` is low, all counters are held at 0. One clock later `x_pos`, `y_pos`, `pclk_en` and `pix_req` read 0 and every timing output sits at its inactive level.
- R11: Synchronous reset brings every output to its inactive level (per `cfg_pol`), zero position, no strobes and a clear status and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the timing at its idle state |
| cfg_hsw | input | CW | Line sync width in pixels |
| cfg_hbp | input | CW | Horizontal back porch in pixels |
| cfg_hact | input | CW | Visible pixels per line |
| cfg_hfp | input | CW | Horizontal front porch in pixels |
| cfg_vsw | input | CW | Frame sync width in lines |
| cfg_vbp | input | CW | Vertical back porch in lines |
| cfg_vact | input | CW | Visible lines per frame |
| cfg_vfp | input | CW | Vertical front porch in lines |
| cfg_div | input | DIVW | Pixel clock divisor minus one |
| cfg_acb | input | ACW | Bias toggle period in lines (0 acts as 1) |
| cfg_pol | input | 4 | Per-signal active-low mask {acb, de, vsync, hsync} |
| cfg_tft | input | 1 | Panel type: 1 active-matrix, 0 passive |
| cfg_vcmp_sel | input | 2 | Vertical compare region select |
| irq_mask | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear for the status bit |
| pclk_en | output | 1 | Pixel clock enable strobe |
| pix_req | output | 1 | Visible-pixel request strobe |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable (active-matrix panels) |
| acb | output | 1 | Bias toggle (passive panels) |
| x_pos | output | CW | Current pixel within the line |
| y_pos | output | CW | Current line within the frame |
| irq_stat | output | 1 | Sticky vertical-compare status |
| irq | output | 1 | Masked interrupt request |

## Verification
Five timing sets are checked by whole-frame counts of every output: unequal porches, divisors from 1 to 4, all polarity masks, both panel types, each compare region, a zero bias period and a line longer than 1024 pixels. Getting a region boundary wrong by one pixel shows up as a wrong sync, enable or request count. Ignoring a polarity bit moves a count to its complement. A bias counter that treats 0 as 256 gives too few toggles. A compare decoder with the regions swapped fires on the wrong `y_pos`. Directed tests cover the idle hold when `en` drops, stickiness while the mask is off, mask-to-pin latency and the clear strobe. Any one of these, if broken, leaves the status or pin at the wrong level in a known cycle.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

  // Vertical compare region select codes
  typedef enum logic [1:0] {
    VC_SYNC  = 2'd0,
    VC_BACK  = 2'd1,
    VC_VIS   = 2'd2,
    VC_FRONT = 2'd3
  } vcmp_sel_e;

  // Bit positions inside the polarity mask
  localparam int POL_HS = 0;
  localparam int POL_VS = 1;
  localparam int POL_DE = 2;
  localparam int POL_AC = 3;
  localparam int NSIG   = 4;

endpackage

// File: rtl/lcd_tgen_pixdiv.sv
module lcd_tgen_pixdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            tick
);

  logic [DIVW-1:0] cnt_q;

  // One pixel slot lasts div+1 core clocks (R1)
  assign tick = en && (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_tgen_raster.sv
module lcd_tgen_raster
  import lcd_tgen_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] hsw,
  input  logic [CW-1:0] hbp,
  input  logic [CW-1:0] hact,
  input  logic [CW-1:0] hfp,
  input  logic [CW-1:0] vsw,
  input  logic [CW-1:0] vbp,
  input  logic [CW-1:0] vact,
  input  logic [CW-1:0] vfp,
  input  logic [1:0]    vsel,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic          h_sync,
  output logic          v_sync,
  output logic          h_vis,
  output logic          v_vis,
  output logic          line_wrap,
  output logic          vcmp_hit
);

  localparam int TW  = CW + 2;  // room for the sum of four CW-wide fields
  localparam int NAX = 2;       // 0 horizontal, 1 vertical

  logic [CW-1:0] sw_a  [NAX];
  logic [CW-1:0] bp_a  [NAX];
  logic [CW-1:0] act_a [NAX];
  logic [CW-1:0] fp_a  [NAX];
  logic [CW-1:0] cnt_a [NAX];
  logic          sync_a[NAX];
  logic          vis_a [NAX];
  logic          mark_a[NAX];

  assign sw_a[0]  = hsw;
  assign bp_a[0]  = hbp;
  assign act_a[0] = hact;
  assign fp_a[0]  = hfp;
  assign sw_a[1]  = vsw;
  assign bp_a[1]  = vbp;
  assign act_a[1] = vact;
  assign fp_a[1]  = vfp;

  for (genvar ax = 0; ax < NAX; ax++) begin : g_axis
    logic [TW-1:0] b_back, b_vis, b_tot, b_sync, pos;
    logic [CW-1:0] cnt_r;
    logic          step_l, wrap_l, mark_l;

    // Region boundaries: sync, back porch, visible, front porch
    assign b_sync = TW'(sw_a[ax]);
    assign b_back = b_sync + TW'(bp_a[ax]);
    assign b_vis  = b_back + TW'(act_a[ax]);
    assign b_tot  = b_vis  + TW'(fp_a[ax]);
    assign pos    = TW'(cnt_r);

    if (ax == 0) begin : g_h
      assign step_l = tick;
      assign mark_l = (pos == '0);
    end else begin : g_v
      assign step_l = line_wrap;
      always_comb begin
        case (vcmp_sel_e'(vsel))
          VC_SYNC:  mark_l = (pos == '0);
          VC_BACK:  mark_l = (pos == b_sync);
          VC_VIS:   mark_l = (pos == b_back);
          VC_FRONT: mark_l = (pos == b_vis);
          default:  mark_l = 1'b0;
        endcase
      end
    end

    assign wrap_l = step_l && ((pos + TW'(1)) >= b_tot);

    always_ff @(posedge clk) begin
      if (rst || !en) begin
        cnt_r <= '0;
      end else if (step_l) begin
        cnt_r <= wrap_l ? '0 : cnt_r + 1'b1;
      end
    end

    assign cnt_a[ax]  = cnt_r;
    assign sync_a[ax] = (pos < b_sync);
    assign vis_a[ax]  = (pos >= b_back) && (pos < b_vis);
    assign mark_a[ax] = mark_l;
  end

  assign line_wrap = g_axis[0].wrap_l;
  assign hcnt      = cnt_a[0];
  assign vcnt      = cnt_a[1];
  assign h_sync    = sync_a[0];
  assign v_sync    = sync_a[1];
  assign h_vis     = vis_a[0];
  assign v_vis     = vis_a[1];
  // First pixel of the selected line (R8)
  assign vcmp_hit  = tick && mark_a[0] && mark_a[1];

endmodule

// File: rtl/lcd_tgen_acbias.sv
module lcd_tgen_acbias #(
  parameter int ACW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           line_step,
  input  logic [ACW-1:0] period,
  output logic           tog
);

  logic [ACW-1:0] cnt_q;
  logic [ACW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;

  // A period of 0 satisfies the compare every line, so it acts as 1 (R6)
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      tog   <= 1'b0;
    end else if (line_step) begin
      if (cnt_nx >= {1'b0, period}) begin
        cnt_q <= '0;
        tog   <= ~tog;
      end else begin
        cnt_q <= cnt_nx[ACW-1:0];
      end
    end
  end

endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
  import lcd_tgen_pkg::*;
#(
  parameter int CW   = 11,
  parameter int DIVW = 8,
  parameter int ACW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [CW-1:0]   cfg_hsw,
  input  logic [CW-1:0]   cfg_hbp,
  input  logic [CW-1:0]   cfg_hact,
  input  logic [CW-1:0]   cfg_hfp,
  input  logic [CW-1:0]   cfg_vsw,
  input  logic [CW-1:0]   cfg_vbp,
  input  logic [CW-1:0]   cfg_vact,
  input  logic [CW-1:0]   cfg_vfp,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [ACW-1:0]  cfg_acb,
  input  logic [3:0]      cfg_pol,
  input  logic            cfg_tft,
  input  logic [1:0]      cfg_vcmp_sel,
  input  logic            irq_mask,
  input  logic            irq_clr,
  output logic            pclk_en,
  output logic            pix_req,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            acb,
  output logic [CW-1:0]   x_pos,
  output logic [CW-1:0]   y_pos,
  output logic            irq_stat,
  output logic            irq
);

  logic          tick;
  logic [CW-1:0] hcnt, vcnt;
  logic          h_sync, v_sync, h_vis, v_vis, line_wrap, vcmp_hit;
  logic          acb_tog;
  logic [NSIG-1:0] act, sig_q;
  logic          stat_q, stat_n;

  lcd_tgen_pixdiv #(.DIVW(DIVW)) u_pixdiv (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .div  (cfg_div),
    .tick (tick)
  );

  lcd_tgen_raster #(.CW(CW)) u_raster (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tick      (tick),
    .hsw       (cfg_hsw),
    .hbp       (cfg_hbp),
    .hact      (cfg_hact),
    .hfp       (cfg_hfp),
    .vsw       (cfg_vsw),
    .vbp       (cfg_vbp),
    .vact      (cfg_vact),
    .vfp       (cfg_vfp),
    .vsel      (cfg_vcmp_sel),
    .hcnt      (hcnt),
    .vcnt      (vcnt),
    .h_sync    (h_sync),
    .v_sync    (v_sync),
    .h_vis     (h_vis),
    .v_vis     (v_vis),
    .line_wrap (line_wrap),
    .vcmp_hit  (vcmp_hit)
  );

  lcd_tgen_acbias #(.ACW(ACW)) u_acbias (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .line_step (line_wrap),
    .period    (cfg_acb),
    .tog       (acb_tog)
  );

  // Active-high view of each timing output before polarity
  assign act[POL_HS] = en & h_sync;
  assign act[POL_VS] = en & v_sync;
  assign act[POL_DE] = en & cfg_tft & h_vis & v_vis;
  assign act[POL_AC] = en & ~cfg_tft & acb_tog;

  assign stat_n = vcmp_hit | (stat_q & ~irq_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q   <= cfg_pol;
      pclk_en <= 1'b0;
      pix_req <= 1'b0;
      x_pos   <= '0;
      y_pos   <= '0;
      stat_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      sig_q   <= act ^ cfg_pol;
      pclk_en <= tick;
      pix_req <= tick & h_vis & v_vis;
      x_pos   <= en ? hcnt : '0;
      y_pos   <= en ? vcnt : '0;
      stat_q  <= stat_n;
      irq     <= stat_n & irq_mask;
    end
  end

  assign hsync    = sig_q[POL_HS];
  assign vsync    = sig_q[POL_VS];
  assign de       = sig_q[POL_DE];
  assign acb      = sig_q[POL_AC];
  assign irq_stat = stat_q;

endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [3:0]    cfg_pol,
  input logic          cfg_tft,
  input logic          irq_mask,
  input logic          irq_clr,
  input logic          pclk_en,
  input logic          pix_req,
  input logic          de,
  input logic          acb,
  input logic [CW-1:0] x_pos,
  input logic [CW-1:0] y_pos,
  input logic          irq_stat,
  input logic          irq
);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (x_pos == '0 && y_pos == '0 && !pclk_en && !pix_req));

  p_req_on_pclk_r5: assert property (@(posedge clk) disable iff (rst)
    pix_req |-> pclk_en);

  p_stat_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_stat && !irq_clr) |=> irq_stat);

  p_mask_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !irq_mask |=> !irq);

  p_stn_no_de_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_tft |=> (de == $past(cfg_pol[2])));

  p_tft_no_acb_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_tft |=> (acb == $past(cfg_pol[3])));

  p_hit_line_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_stat) |-> (x_pos == '0));

endmodule

bind lcd_tgen lcd_tgen_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .cfg_pol  (cfg_pol),
  .cfg_tft  (cfg_tft),
  .irq_mask (irq_mask),
  .irq_clr  (irq_clr),
  .pclk_en  (pclk_en),
  .pix_req  (pix_req),
  .de       (de),
  .acb      (acb),
  .x_pos    (x_pos),
  .y_pos    (y_pos),
  .irq_stat (irq_stat),
  .irq      (irq)
);

// File: tb/lcd_tgen_bench.sv
`timescale 1ns/1ps
module lcd_tgen_bench;

  localparam int CW = 11, DIVW = 8, ACW = 8;

  typedef struct packed {
    logic [10:0] hsw, hbp, hact, hfp, vsw, vbp, vact, vfp;
    logic [7:0]  div, acb;
    logic [3:0]  pol;
    logic        tft;
    logic [1:0]  sel;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{11'd2, 11'd3, 11'd8,    11'd2, 11'd1, 11'd2, 11'd5,  11'd1, 8'd0, 8'd3, 4'h0, 1'b1, 2'd2},
    '{11'd1, 11'd1, 11'd4,    11'd1, 11'd2, 11'd1, 11'd3,  11'd2, 8'd2, 8'd4, 4'hF, 1'b0, 2'd0},
    '{11'd3, 11'd2, 11'd16,   11'd3, 11'd2, 11'd2, 11'd10, 11'd2, 8'd1, 8'd0, 4'h5, 1'b1, 2'd3},
    '{11'd1, 11'd0, 11'd5,    11'd0, 11'd1, 11'd0, 11'd4,  11'd1, 8'd3, 8'd0, 4'hA, 1'b0, 2'd1},
    '{11'd1, 11'd1, 11'd1030, 11'd1, 11'd1, 11'd1, 11'd2,  11'd1, 8'd0, 8'd5, 4'h0, 1'b1, 2'd2}
  };

  logic clk = 1'b0;
  logic rst, en, cfg_tft, irq_mask, irq_clr;
  logic [CW-1:0] cfg_hsw, cfg_hbp, cfg_hact, cfg_hfp, cfg_vsw, cfg_vbp, cfg_vact, cfg_vfp;
  logic [DIVW-1:0] cfg_div;
  logic [ACW-1:0]  cfg_acb;
  logic [3:0] cfg_pol;
  logic [1:0] cfg_vcmp_sel;
  logic pclk_en, pix_req, hsync, vsync, de, acb, irq_stat, irq;
  logic [CW-1:0] x_pos, y_pos;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  lcd_tgen #(.CW(CW), .DIVW(DIVW), .ACW(ACW)) u_lcd_tgen (
    .clk(clk), .rst(rst), .en(en),
    .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
    .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .cfg_div(cfg_div), .cfg_acb(cfg_acb), .cfg_pol(cfg_pol), .cfg_tft(cfg_tft),
    .cfg_vcmp_sel(cfg_vcmp_sel), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .pclk_en(pclk_en), .pix_req(pix_req), .hsync(hsync), .vsync(vsync), .de(de),
    .acb(acb), .x_pos(x_pos), .y_pos(y_pos), .irq_stat(irq_stat), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg_hsw = v.hsw; cfg_hbp = v.hbp; cfg_hact = v.hact; cfg_hfp = v.hfp;
    cfg_vsw = v.vsw; cfg_vbp = v.vbp; cfg_vact = v.vact; cfg_vfp = v.vfp;
    cfg_div = v.div; cfg_acb = v.acb; cfg_pol = v.pol; cfg_tft = v.tft;
    cfg_vcmp_sel = v.sel;
  endtask

  task automatic run_vec(input vec_t v);
    int htot = int'(v.hsw) + int'(v.hbp) + int'(v.hact) + int'(v.hfp);
    int vtot = int'(v.vsw) + int'(v.vbp) + int'(v.vact) + int'(v.vfp);
    int dv   = int'(v.div) + 1;
    int nwin = htot * vtot * dv;
    int ap   = (v.acb == 0) ? 1 : int'(v.acb);
    int tgt;
    int n_pclk = 0, n_hs = 0, n_vs = 0, n_de = 0, n_req = 0, n_tog = 0, n_irq = 0;
    int n_bad = 0, xmax = 0, ymax = 0;
    logic prev_ac;
    case (v.sel)
      2'd0: tgt = 0;
      2'd1: tgt = int'(v.vsw);
      2'd2: tgt = int'(v.vsw) + int'(v.vbp);
      default: tgt = int'(v.vsw) + int'(v.vbp) + int'(v.vact);
    endcase
    @(negedge clk);
    en = 1'b0; apply_cfg(v); irq_clr = 1'b1; irq_mask = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    prev_ac = acb ^ v.pol[3];
    repeat (nwin) begin
      @(negedge clk);
      n_pclk += int'(pclk_en);
      n_req  += int'(pix_req);
      n_hs   += int'(hsync ^ v.pol[0]);
      n_vs   += int'(vsync ^ v.pol[1]);
      n_de   += int'(de ^ v.pol[2]);
      if ((acb ^ v.pol[3]) != prev_ac) n_tog++;
      prev_ac = acb ^ v.pol[3];
      if (irq_stat) begin
        n_irq++;
        if (int'(y_pos) != tgt || x_pos != '0) n_bad++;
      end
      if (int'(x_pos) > xmax) xmax = int'(x_pos);
      if (int'(y_pos) > ymax) ymax = int'(y_pos);
    end
    chk("R1", "pclk_en pulses per frame", n_pclk, htot * vtot);
    chk("R2", "hsync active clocks", n_hs, int'(v.hsw) * dv * vtot);
    chk("R2", "x_pos maximum", xmax, htot - 1);
    chk("R3", "vsync active clocks", n_vs, int'(v.vsw) * htot * dv);
    chk("R3", "y_pos maximum", ymax, vtot - 1);
    chk("R4", "de active clocks", n_de, v.tft ? int'(v.hact) * int'(v.vact) * dv : 0);
    chk("R5", "pix_req strobes", n_req, int'(v.hact) * int'(v.vact));
    chk("R6", "acb toggles (R7 polarity applied)", n_tog, v.tft ? 0 : vtot / ap);
    chk("R9", "status pulses with clear held", n_irq, 1);
    chk("R8", "compare events off target line", n_bad, 0);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; irq_mask = 1'b0; irq_clr = 1'b0;
    apply_cfg(VECS[0]);
    cfg_pol = 4'b0110;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state, inactive levels follow R7 mask
    chk("R11", "hsync reset", int'(hsync), 0);
    chk("R11", "vsync reset", int'(vsync), 1);
    chk("R11", "de reset", int'(de), 1);
    chk("R11", "acb reset", int'(acb), 0);
    chk("R11", "x_pos reset", int'(x_pos), 0);
    chk("R11", "y_pos reset", int'(y_pos), 0);
    chk("R11", "pclk_en reset", int'(pclk_en), 0);
    chk("R11", "irq_stat reset", int'(irq_stat), 0);
    chk("R11", "irq reset", int'(irq), 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R10: idle hold with last vector's polarity (4'h0)
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R10", "x_pos idle", int'(x_pos), 0);
    chk("R10", "y_pos idle", int'(y_pos), 0);
    chk("R10", "hsync idle", int'(hsync), 0);
    chk("R10", "de idle", int'(de), 0);
    begin
      int np = 0;
      repeat (20) begin @(negedge clk); np += int'(pclk_en) + int'(pix_req); end
      chk("R10", "strobes while disabled", np, 0);
    end

    // R9/R8: sticky status and mask
    apply_cfg(VECS[0]);
    cfg_vcmp_sel = 2'd0;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0; irq_mask = 1'b0; en = 1'b1;
    begin
      int guard = 0;
      while (!irq_stat && guard < 400) begin @(negedge clk); guard++; end
      chk("R8", "compare at sync start seen", int'(irq_stat), 1);
      chk("R8", "y_pos at compare", int'(y_pos), 0);
    end
    repeat (5) @(negedge clk);
    chk("R9", "status sticky", int'(irq_stat), 1);
    chk("R9", "irq masked", int'(irq), 0);
    irq_mask = 1'b1;
    @(negedge clk);
    chk("R9", "irq after unmask", int'(irq), 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9", "status cleared", int'(irq_stat), 0);
    chk("R9", "irq cleared", int'(irq), 0);
    repeat (3) @(negedge clk);
    chk("R9", "status stays clear", int'(irq_stat), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule